// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit decides, for one fetched instruction of a 32-bit MIPS-I style core, whether control flow changes and where it goes next. It takes the instruction word, the address of that instruction and the two source register values already read by the register file. From these it produces a taken flag, the next fetch address, a link-register write (enable, index and value) for the linking forms, and a flag telling the pipeline that the following instruction sits in a delay slot.

All results are computed combinationally and registered once, so they appear one clock after the inputs are presented. A new instruction can be presented every cycle. Fetch, the register file, hazard handling and execution of the delay-slot instruction are left to the surrounding pipeline. The link register used by the fixed-target linking forms is a parameter, 31 by default.

Top module: `ctl_flow_resolver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero.
- R2: Opcode 4 (equal compare) is taken when the two source values are identical; opcode 5 (not-equal compare) is taken exactly when they differ.
- R3: Opcode 1 selects sign tests on the first source by the rt field: values 0 and 16 are taken when its bit 31 is set, values 1 and 17 when bit 31 is clear; values 16 and 17 also link.
- R4: Opcode 6 is taken when the first source, read as signed, is zero or negative; opcode 7 when it is strictly positive.
- R5: A taken conditional branch targets the instruction address plus 4 plus the sign-extended 16-bit immediate shifted left by 2.
- R6: Opcodes 2 and 3 are always taken, with a target keeping bits 31:28 of the instruction address and filling bits 27:0 with the 26-bit index shifted left by 2.
- R7: Opcode 0 with function 8 or 9 is always taken, with the first source value as the target.
- R8: Opcode 3 and the linking sign tests write the instruction address plus 8 to the link register whether or not the branch is taken; without a link write the link index and value outputs are zero.
- R9: Opcode 0 with function 9 links the instruction address plus 8 into the register named by bits 15:11; when that index is 0 no write is issued.
- R10: Every recognised branch or jump raises the delay-slot flag, taken or not.
- R11: Any other opcode, function or rt-field combination yields taken 0, no link write, no delay-slot flag and next address plus 4.
- R12: A recognised branch that is not taken gives next address equal to the instruction address plus 4.
- R13: Each result appears on the outputs one clock after its inputs and a new instruction is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| taken_o | output | 1 | Control flow redirects |
| next_pc_o | output | 32 | Next fetch address |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 32 | Link value |
| delay_slot_o | output | 1 | Following instruction is a delay slot |

## Verification
The assertions assume that the instruction, address and source values of one cycle all belong to the same instruction and are stable at the clock edge, and that the inputs are known from the first edge after reset; they compare registered outputs against the inputs of the previous edge only once a full cycle has passed since reset. The stimulus drives all four inputs together away from the edge, builds instructions from the recognised opcode set plus deliberately invalid function and rt values, and biases source values toward zero, equal pairs and the sign boundary so that every compare sits on its edge often. Directed cases add a zero link index, the highest address segment and negative offsets.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OPC_SPECIAL = 6'd0;
    localparam logic [5:0] OPC_REGIMM  = 6'd1;
    localparam logic [5:0] OPC_J       = 6'd2;
    localparam logic [5:0] OPC_JAL     = 6'd3;
    localparam logic [5:0] OPC_BEQ     = 6'd4;
    localparam logic [5:0] OPC_BNE     = 6'd5;
    localparam logic [5:0] OPC_BLEZ    = 6'd6;
    localparam logic [5:0] OPC_BGTZ    = 6'd7;

    localparam logic [5:0] FN_JR   = 6'd8;
    localparam logic [5:0] FN_JALR = 6'd9;

    localparam logic [4:0] RI_LTZ   = 5'd0;
    localparam logic [4:0] RI_GEZ   = 5'd1;
    localparam logic [4:0] RI_LTZL  = 5'd16;
    localparam logic [4:0] RI_GEZL  = 5'd17;

    typedef enum logic [3:0] {
        FK_NONE,
        FK_EQ,
        FK_NE,
        FK_LEZ,
        FK_GTZ,
        FK_LTZ,
        FK_GEZ,
        FK_ABS,
        FK_REG
    } flow_kind_e;

    typedef struct packed {
        flow_kind_e          kind;
        logic                link;
        logic [RIDX_W-1:0]   link_idx;
    } flow_dec_t;

    typedef struct packed {
        logic                taken;
        logic [XLEN-1:0]     next_pc;
        logic                link_we;
        logic [RIDX_W-1:0]   link_idx;
        logic [XLEN-1:0]     link_val;
        logic                delay_slot;
    } flow_res_t;
endpackage

// File: rtl/cfr_decode.sv
module cfr_decode
    import cfr_pkg::*;
#(
    parameter logic [RIDX_W-1:0] LINK_REG = 5'd31
) (
    input  logic [5:0]        opc_i,
    input  logic [4:0]        rt_f_i,
    input  logic [4:0]        rd_f_i,
    input  logic [5:0]        funct_i,
    output flow_dec_t         dec_o
);
    always_comb begin
        dec_o.kind     = FK_NONE;
        dec_o.link     = 1'b0;
        dec_o.link_idx = '0;
        case (opc_i)
            OPC_BEQ:  dec_o.kind = FK_EQ;
            OPC_BNE:  dec_o.kind = FK_NE;
            OPC_BLEZ: dec_o.kind = FK_LEZ;
            OPC_BGTZ: dec_o.kind = FK_GTZ;
            OPC_J:    dec_o.kind = FK_ABS;
            OPC_JAL: begin
                dec_o.kind     = FK_ABS;
                dec_o.link     = 1'b1;
                dec_o.link_idx = LINK_REG;
            end
            OPC_REGIMM: begin
                case (rt_f_i)
                    RI_LTZ, RI_LTZL: dec_o.kind = FK_LTZ;
                    RI_GEZ, RI_GEZL: dec_o.kind = FK_GEZ;
                    default:         dec_o.kind = FK_NONE;
                endcase
                if (rt_f_i == RI_LTZL || rt_f_i == RI_GEZL) begin
                    dec_o.link     = 1'b1;
                    dec_o.link_idx = LINK_REG;
                end
            end
            OPC_SPECIAL: begin
                if (funct_i == FN_JR) begin
                    dec_o.kind = FK_REG;
                end else if (funct_i == FN_JALR) begin
                    dec_o.kind = FK_REG;
                    if (rd_f_i != '0) begin
                        dec_o.link     = 1'b1;
                        dec_o.link_idx = rd_f_i;
                    end
                end
            end
            default: dec_o.kind = FK_NONE;
        endcase
    end
endmodule

// File: rtl/cfr_cond.sv
module cfr_cond
    import cfr_pkg::*;
(
    input  flow_kind_e        kind_i,
    input  logic [XLEN-1:0]   rs_i,
    input  logic [XLEN-1:0]   rt_i,
    output logic              take_o
);
    logic rs_neg;
    logic rs_zero;
    logic same;

    assign rs_neg  = rs_i[XLEN-1];
    assign rs_zero = (rs_i == '0);
    assign same    = (rs_i == rt_i);

    always_comb begin
        case (kind_i)
            FK_EQ:   take_o = same;
            FK_NE:   take_o = !same;
            FK_LEZ:  take_o = rs_neg || rs_zero;
            FK_GTZ:  take_o = !rs_neg && !rs_zero;
            FK_LTZ:  take_o = rs_neg;
            FK_GEZ:  take_o = !rs_neg;
            FK_ABS:  take_o = 1'b1;
            FK_REG:  take_o = 1'b1;
            default: take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfr_target.sv
module cfr_target
    import cfr_pkg::*;
(
    input  flow_kind_e        kind_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [15:0]       imm_i,
    input  logic [25:0]       jidx_i,
    input  logic [XLEN-1:0]   rs_i,
    output logic [XLEN-1:0]   seq_o,
    output logic [XLEN-1:0]   tgt_o,
    output logic [XLEN-1:0]   link_o
);
    localparam int SEG_W = XLEN - 28;

    logic [XLEN-1:0] br_off;

    assign br_off = {{(XLEN-18){imm_i[15]}}, imm_i, 2'b00};
    assign seq_o  = pc_i + XLEN'(4);
    assign link_o = pc_i + XLEN'(8);

    always_comb begin
        case (kind_i)
            FK_ABS:  tgt_o = {pc_i[XLEN-1 -: SEG_W], jidx_i, 2'b00};
            FK_REG:  tgt_o = rs_i;
            default: tgt_o = seq_o + br_off;
        endcase
    end
endmodule

// File: rtl/ctl_flow_resolver.sv
module ctl_flow_resolver
    import cfr_pkg::*;
#(
    parameter logic [RIDX_W-1:0] LINK_REG = 5'd31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XLEN-1:0]     instr_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [XLEN-1:0]     rs_val_i,
    input  logic [XLEN-1:0]     rt_val_i,
    output logic                taken_o,
    output logic [XLEN-1:0]     next_pc_o,
    output logic                link_we_o,
    output logic [RIDX_W-1:0]   link_idx_o,
    output logic [XLEN-1:0]     link_val_o,
    output logic                delay_slot_o
);
    flow_dec_t       dec;
    logic            cond_take;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] tgt_pc;
    logic [XLEN-1:0] link_pc;
    flow_res_t       res_d;
    flow_res_t       res_q;
    logic            primed_q;

    cfr_decode #(.LINK_REG(LINK_REG)) u_dec (
        .opc_i   (instr_i[31:26]),
        .rt_f_i  (instr_i[20:16]),
        .rd_f_i  (instr_i[15:11]),
        .funct_i (instr_i[5:0]),
        .dec_o   (dec)
    );

    cfr_cond u_cond (
        .kind_i (dec.kind),
        .rs_i   (rs_val_i),
        .rt_i   (rt_val_i),
        .take_o (cond_take)
    );

    cfr_target u_tgt (
        .kind_i (dec.kind),
        .pc_i   (pc_i),
        .imm_i  (instr_i[15:0]),
        .jidx_i (instr_i[25:0]),
        .rs_i   (rs_val_i),
        .seq_o  (seq_pc),
        .tgt_o  (tgt_pc),
        .link_o (link_pc)
    );

    always_comb begin
        res_d            = '0;
        res_d.delay_slot = (dec.kind != FK_NONE);
        res_d.taken      = cond_take;
        res_d.next_pc    = cond_take ? tgt_pc : seq_pc;
        res_d.link_we    = dec.link;
        res_d.link_idx   = dec.link ? dec.link_idx : '0;
        res_d.link_val   = dec.link ? link_pc : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            res_q    <= res_d;
            primed_q <= 1'b1;
        end
    end

    assign taken_o      = res_q.taken;
    assign next_pc_o    = res_q.next_pc;
    assign link_we_o    = res_q.link_we;
    assign link_idx_o   = res_q.link_idx;
    assign link_val_o   = res_q.link_val;
    assign delay_slot_o = res_q.delay_slot;

    // R10, R11: without the delay-slot flag nothing redirects or links
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !delay_slot_o |-> (!taken_o && !link_we_o));

    // R12: fall-through address follows the previous instruction address
    p_seq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !taken_o) |-> (next_pc_o == $past(pc_i) + 32'd4));

    // R8: link value is the address two words past the instruction
    p_link_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && link_we_o) |-> (link_val_o == $past(pc_i) + 32'd8));

    // R9: register zero is never a link destination
    p_no_r0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_idx_o != '0));

    // R6: absolute jumps keep the address segment
    p_seg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(instr_i[31:27] == 5'b00001)) |->
        (taken_o && next_pc_o[31:28] == $past(pc_i[31:28])));

    // R7: register jumps land on the first source value
    p_reg_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(instr_i[31:26] == OPC_SPECIAL && instr_i[5:1] == 5'b00100))
        |-> (taken_o && next_pc_o == $past(rs_val_i)));
endmodule

// File: tb/sim_ctl_flow_resolver.sv
module sim_ctl_flow_resolver;
    import cfr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic [31:0] rsv = '0;
    logic [31:0] rtv = '0;
    logic        taken;
    logic [31:0] next_pc;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_val;
    logic        dslot;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctl_flow_resolver u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .pc_i(pc),
        .rs_val_i(rsv), .rt_val_i(rtv), .taken_o(taken), .next_pc_o(next_pc),
        .link_we_o(link_we), .link_idx_o(link_idx), .link_val_o(link_val),
        .delay_slot_o(dslot)
    );

    function automatic flow_res_t model(logic [31:0] ins, logic [31:0] a,
                                        logic [31:0] s, logic [31:0] t);
        flow_res_t m;
        logic      rec;
        logic      tk;
        logic [31:0] tgt;
        logic [4:0] li;
        m   = '0;
        rec = 1'b1;
        tk  = 1'b0;
        li  = 5'd0;
        tgt = a + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
        case (ins[31:26])
            6'd4: tk = (s == t);
            6'd5: tk = (s != t);
            6'd6: tk = ($signed(s) <= 0);
            6'd7: tk = ($signed(s) > 0);
            6'd2, 6'd3: begin
                tk  = 1'b1;
                tgt = {a[31:28], ins[25:0], 2'b00};
                if (ins[26]) li = 5'd31;
            end
            6'd1: begin
                if (ins[20:16] == 5'd0 || ins[20:16] == 5'd16) tk = $signed(s) < 0;
                else if (ins[20:16] == 5'd1 || ins[20:16] == 5'd17) tk = $signed(s) >= 0;
                else rec = 1'b0;
                if (rec && ins[20]) li = 5'd31;
            end
            6'd0: begin
                if (ins[5:0] == 6'd8 || ins[5:0] == 6'd9) begin
                    tk  = 1'b1;
                    tgt = s;
                    if (ins[5:0] == 6'd9) li = ins[15:11];
                end else rec = 1'b0;
            end
            default: rec = 1'b0;
        endcase
        m.taken      = tk;
        m.next_pc    = tk ? tgt : a + 32'd4;
        m.delay_slot = rec;
        m.link_we    = (li != 5'd0);
        m.link_idx   = li;
        m.link_val   = (li != 5'd0) ? a + 32'd8 : 32'd0;
        return m;
    endfunction

    task automatic check(string req, flow_res_t e);
        n_chk++;
        if (taken !== e.taken || next_pc !== e.next_pc || link_we !== e.link_we ||
            link_idx !== e.link_idx || link_val !== e.link_val || dslot !== e.delay_slot) begin
            n_bad++;
            $display("FAIL %s: got tk=%0b pc=%h lw=%0b li=%0d lv=%h ds=%0b exp tk=%0b pc=%h lw=%0b li=%0d lv=%h ds=%0b",
                     req, taken, next_pc, link_we, link_idx, link_val, dslot,
                     e.taken, e.next_pc, e.link_we, e.link_idx, e.link_val, e.delay_slot);
        end
    endtask

    // one instruction per call: drive at a falling edge, read after the next rising edge
    task automatic vec(string req, logic [31:0] ins, logic [31:0] a,
                       logic [31:0] s, logic [31:0] t);
        instr = ins; pc = a; rsv = s; rtv = t;
        @(negedge clk);
        check(req, model(ins, a, s, t));
    endtask

    function automatic logic [31:0] itype(logic [5:0] op, logic [4:0] rf, logic [15:0] imm);
        return {op, 5'd3, rf, imm};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        flow_res_t zero_r;
        int unsigned seed;
        zero_r = '0;
        seed = 32'd2718;
        void'($urandom(seed));
        instr = itype(6'd3, 5'd0, 16'h1234);
        pc = 32'h0040_0000;
        repeat (3) @(negedge clk);
        check("R1 in reset", zero_r);
        rst_n = 1'b1;
        check("R1 first cycle", zero_r);

        // R2 compare forms, equal and different
        vec("R2 beq eq",  itype(6'd4, 5'd2, 16'h0010), 32'h1000_0100, 32'h55, 32'h55);
        vec("R2 beq ne",  itype(6'd4, 5'd2, 16'h0010), 32'h1000_0100, 32'h55, 32'h56);
        vec("R2 bne ne",  itype(6'd5, 5'd2, 16'hfff0), 32'h1000_0100, 1, 2);
        // R3 sign tests at the boundary
        vec("R3 ltz min",  itype(6'd1, 5'd0, 16'h0004), 32'h200, 32'h8000_0000, 0);
        vec("R3 gez zero", itype(6'd1, 5'd1, 16'h0004), 32'h200, 32'h0, 0);
        vec("R3 R8 ltzl not taken", itype(6'd1, 5'd16, 16'h0004), 32'h300, 32'h7fff_ffff, 0);
        vec("R3 R8 gezl taken", itype(6'd1, 5'd17, 16'h8000), 32'h300, 32'h0, 0);
        // R4 around zero
        vec("R4 lez zero", itype(6'd6, 5'd0, 16'h0002), 32'h400, 32'h0, 0);
        vec("R4 gtz zero", itype(6'd7, 5'd0, 16'h0002), 32'h400, 32'h0, 0);
        vec("R4 gtz one",  itype(6'd7, 5'd0, 16'h0002), 32'h400, 32'h1, 0);
        // R5 negative offset
        vec("R5 back",     itype(6'd4, 5'd0, 16'hffff), 32'h0000_1000, 7, 7);
        // R6 top segment
        vec("R6 j seg",    {6'd2, 26'h3ff_ffff}, 32'hf000_0040, 0, 0);
        vec("R6 R8 jal",   {6'd3, 26'h000_0001}, 32'hffff_fff8, 0, 0);
        // R7 R9 register jumps
        vec("R7 jr",       {6'd0, 5'd4, 5'd0, 5'd0, 5'd0, 6'd8}, 32'h500, 32'hdead_beec, 0);
        vec("R9 jalr rd",  {6'd0, 5'd4, 5'd0, 5'd9, 5'd0, 6'd9}, 32'h500, 32'h1234_5678, 0);
        vec("R9 jalr r0",  {6'd0, 5'd4, 5'd0, 5'd0, 5'd0, 6'd9}, 32'h500, 32'h1234_5678, 0);
        // R11 undecoded forms
        vec("R11 alu op",  itype(6'd8, 5'd1, 16'h0001), 32'h600, 0, 0);
        vec("R11 regimm",  itype(6'd1, 5'd2, 16'h0001), 32'h600, 32'h8000_0000, 0);
        vec("R11 special", {6'd0, 5'd4, 5'd0, 5'd31, 5'd0, 6'd10}, 32'h600, 32'h99, 0);

        // R13 back-to-back random stream, R2..R12 across all classes
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] ins;
            logic [31:0] a;
            logic [31:0] s;
            logic [31:0] t;
            int cls;
            cls = $urandom_range(0, 9);
            ins = $urandom;
            a   = {$urandom, 2'b00} >> 0;
            a[1:0] = 2'b00;
            case (cls)
                0: ins[31:26] = 6'd4;
                1: ins[31:26] = 6'd5;
                2: ins[31:26] = 6'd6;
                3: ins[31:26] = 6'd7;
                4: begin
                    ins[31:26] = 6'd1;
                    case ($urandom_range(0, 4))
                        0: ins[20:16] = 5'd0;
                        1: ins[20:16] = 5'd1;
                        2: ins[20:16] = 5'd16;
                        3: ins[20:16] = 5'd17;
                        default: ins[20:16] = 5'($urandom_range(2, 15));
                    endcase
                end
                5: ins[31:26] = 6'($urandom_range(2, 3));
                6: begin
                    ins[31:26] = 6'd0;
                    ins[5:0]   = 6'($urandom_range(7, 10));
                end
                default: ins[31:26] = 6'($urandom_range(0, 63));
            endcase
            s = $urandom;
            t = $urandom;
            case ($urandom_range(0, 5))
                0: s = 32'h0;
                1: t = s;
                2: s = 32'h8000_0000;
                3: s = 32'h0000_0001;
                default: ;
            endcase
            vec("R13 stream", ins, a, s, t);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule